// File: doc/BRIEF.md
# Audio Codec Power-Down Controller

This block is the digital power-management controller of a stereo audio codec. It owns the power-down control/status register at register index 26h, reached through a simple host register port. Seven control bits switch off codec sections one at a time: the input ADCs, the output DACs, the analog mixer, the bias/reference, the serial link interface, the internal clock and the line-level output. Each section gets its own enable output.

For three analog sections and the reference, the register also reports a ready flag. A small settling counter models the time each section needs to become stable after power-up. Some bits only take effect in a safe order. The reference bit needs the three lower analog bits. The link bit needs both the ADC and DAC bits. While the link is down the register is frozen.

Software brings the codec back in one of two ways. A warm reset, which is a long high pulse on SYNC while the link is down, clears only the link bit. A cold reset, the active-low reset input, restores every default. `clk_i` is the free-running bit clock and serves as the block clock.

Top module: `codec_pwr_ctrl`

## Requirements
- R1: A read at address 7'h26 returns {1'b0, pd[6:0] in bits 14:8, 4'b0000, ready[3:0] in bits 3:0}, where ready bit 0 is ADC, bit 1 is DAC, bit 2 is mixer and bit 3 is reference. A read at any other address returns 16'h0000.
- R2: Control bits 8 (ADC), 9 (DAC) and 10 (mixer) are taken from a write individually or in any combination. A set bit drives the matching enable output low.
- R3: Bit 11 (reference off) is stored only if the same write also sets bits 8, 9 and 10. Otherwise bit 11 stays 0 while the other bits are written.
- R4: Bit 12 (link off) is stored only if bits 8 and 9 are already set in the register and are also set in the write. Bits 10 and 11 are not required.
- R5: While bit 12 is set, writes to the register are ignored.
- R6: While bit 12 is set, SYNC sampled high on WARM_CYC consecutive clocks (default 16) clears bit 12 and leaves every other bit unchanged. A shorter pulse has no effect.
- R7: SYNC pulses while bit 12 is clear have no effect on the register.
- R8: A ready flag falls in the same cycle its section is powered down. It rises SETTLE_CYC clocks (default 64) after power-up.
- R9: Cold reset (rst_ni low) clears all control bits, drives every enable output high and clears the ready flags, which then settle per R8.
- R10: Bit 11 drives the ADC, DAC, mixer and reference enables low. Bit 13 drives clk_en_o low and bit 14 drives lnout_en_o low.
- R11: Writes to bits 3:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bit clock, free running |
| rst_ni | input | 1 | Cold reset, active low, asynchronous |
| sync_i | input | 1 | Link SYNC line |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register index |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for reg_addr_i |
| adc_en_o | output | 1 | ADC and input mux power enable |
| dac_en_o | output | 1 | DAC power enable |
| mix_en_o | output | 1 | Analog mixer power enable |
| vref_en_o | output | 1 | Bias/reference power enable |
| link_en_o | output | 1 | Link interface enable |
| clk_en_o | output | 1 | Internal clock enable |
| lnout_en_o | output | 1 | Line-level output enable |

## Verification
A corrupted control bit appears on an enable output and in the readback on the very next clock after the write or SYNC edge that caused it. That makes an ordering violation or a lost warm reset visible immediately. A settling counter that is off by one shows up only at the exact cycle a ready flag rises. The bench therefore samples one cycle before that cycle and at that cycle. A warm-reset detector that does not restart its count on a low SYNC would reopen the link after a split pulse. A pulse one clock short of the limit exposes this.

// File: rtl/codec_pwr_pkg.sv
package codec_pwr_pkg;
  localparam int unsigned ADDR_W = 7;
  localparam int unsigned DATA_W = 16;
  localparam int unsigned PD_W   = 7;
  localparam int unsigned RDY_W  = 4;
  localparam logic [ADDR_W-1:0] PD_IDX = 7'h26;
  localparam int unsigned PD_LSB = 8;
  // control bit positions inside pd[]
  localparam int unsigned B_ADC  = 0;
  localparam int unsigned B_DAC  = 1;
  localparam int unsigned B_MIX  = 2;
  localparam int unsigned B_VREF = 3;
  localparam int unsigned B_LINK = 4;
  localparam int unsigned B_ICLK = 5;
  localparam int unsigned B_LOUT = 6;
endpackage

// File: rtl/codec_pwr_reg.sv
module codec_pwr_reg
  import codec_pwr_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              warm_i,
  output logic [PD_W-1:0]   pd_o
);
  logic [PD_W-1:0] pd_q, pd_d, w;

  assign w = wdata_i[PD_LSB +: PD_W];

  always_comb begin
    pd_d = pd_q;
    if (warm_i) begin
      pd_d[B_LINK] = 1'b0;
    end else if (wr_i && addr_i == PD_IDX && !pd_q[B_LINK]) begin
      pd_d[B_ADC]  = w[B_ADC];
      pd_d[B_DAC]  = w[B_DAC];
      pd_d[B_MIX]  = w[B_MIX];
      pd_d[B_VREF] = w[B_VREF] & w[B_ADC] & w[B_DAC] & w[B_MIX];
      pd_d[B_LINK] = w[B_LINK] & w[B_ADC] & w[B_DAC] & pd_q[B_ADC] & pd_q[B_DAC];
      pd_d[B_ICLK] = w[B_ICLK];
      pd_d[B_LOUT] = w[B_LOUT];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pd_q <= '0;
    else         pd_q <= pd_d;
  end

  assign pd_o = pd_q;
endmodule

// File: rtl/codec_warm_det.sv
module codec_warm_det #(
  parameter int unsigned WARM_CYC = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic link_down_i,
  input  logic sync_i,
  output logic warm_o
);
  localparam int unsigned CW = $clog2(WARM_CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(WARM_CYC - 1);

  logic [CW-1:0] cnt_q;

  assign warm_o = link_down_i && sync_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                cnt_q <= '0;
    else if (!link_down_i || !sync_i || warm_o) cnt_q <= '0;
    else                                        cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/codec_settle_tmr.sv
module codec_settle_tmr #(
  parameter int unsigned SETTLE_CYC = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic ready_o
);
  localparam int unsigned CW = $clog2(SETTLE_CYC + 1);
  localparam logic [CW-1:0] DONE = CW'(SETTLE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (!en_i)         cnt_q <= '0;
    else if (cnt_q != DONE) cnt_q <= cnt_q + 1'b1;
  end

  // drop at once on power-down, rise only when settled
  assign ready_o = en_i && (cnt_q == DONE);
endmodule

// File: rtl/codec_pwr_ctrl.sv
module codec_pwr_ctrl
  import codec_pwr_pkg::*;
#(
  parameter int unsigned SETTLE_CYC = 64,
  parameter int unsigned WARM_CYC   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sync_i,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              adc_en_o,
  output logic              dac_en_o,
  output logic              mix_en_o,
  output logic              vref_en_o,
  output logic              link_en_o,
  output logic              clk_en_o,
  output logic              lnout_en_o
);
  logic [PD_W-1:0]  pd_q;
  logic [RDY_W-1:0] rdy;
  logic [RDY_W-1:0] sec_en;
  logic             warm;

  codec_pwr_reg u_reg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (reg_wr_i),
    .addr_i  (reg_addr_i),
    .wdata_i (reg_wdata_i),
    .warm_i  (warm),
    .pd_o    (pd_q)
  );

  codec_warm_det #(.WARM_CYC(WARM_CYC)) u_warm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .link_down_i (pd_q[B_LINK]),
    .sync_i      (sync_i),
    .warm_o      (warm)
  );

  assign sec_en[0] = ~(pd_q[B_ADC] | pd_q[B_VREF]);
  assign sec_en[1] = ~(pd_q[B_DAC] | pd_q[B_VREF]);
  assign sec_en[2] = ~(pd_q[B_MIX] | pd_q[B_VREF]);
  assign sec_en[3] = ~pd_q[B_VREF];

  for (genvar i = 0; i < RDY_W; i++) begin : g_settle
    codec_settle_tmr #(.SETTLE_CYC(SETTLE_CYC)) u_tmr (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .en_i    (sec_en[i]),
      .ready_o (rdy[i])
    );
  end

  assign adc_en_o   = sec_en[0];
  assign dac_en_o   = sec_en[1];
  assign mix_en_o   = sec_en[2];
  assign vref_en_o  = sec_en[3];
  assign link_en_o  = ~pd_q[B_LINK];
  assign clk_en_o   = ~pd_q[B_ICLK];
  assign lnout_en_o = ~pd_q[B_LOUT];

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == PD_IDX) begin
      reg_rdata_o[PD_LSB +: PD_W] = pd_q;
      reg_rdata_o[RDY_W-1:0]      = rdy;
    end
  end
endmodule

// File: rtl/codec_pwr_chk.sv
module codec_pwr_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       sync_i,
  input logic [6:0] pd_q,
  input logic [3:0] rdy,
  input logic       adc_en_o,
  input logic       dac_en_o,
  input logic       mix_en_o,
  input logic       vref_en_o
);
  a_r3_vref_needs_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_q[3] |-> (pd_q[0] && pd_q[1] && pd_q[2]));

  a_r4_link_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pd_q[4]) |-> $past(pd_q[0] && pd_q[1]));

  // R5 and R6: nothing but the link bit moves while the link is down
  a_r5_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(pd_q[4]) |-> (pd_q[3:0] == $past(pd_q[3:0]) && pd_q[6:5] == $past(pd_q[6:5])));

  a_r6_warm_needs_sync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pd_q[4]) |-> $past(sync_i));

  a_r8_adc_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[0]) |-> $past(adc_en_o));
  a_r8_dac_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[1]) |-> $past(dac_en_o));
  a_r8_mix_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[2]) |-> $past(mix_en_o));
  a_r8_vref_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy[3]) |-> $past(vref_en_o));
endmodule

bind codec_pwr_ctrl codec_pwr_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .sync_i    (sync_i),
  .pd_q      (pd_q),
  .rdy       (rdy),
  .adc_en_o  (adc_en_o),
  .dac_en_o  (dac_en_o),
  .mix_en_o  (mix_en_o),
  .vref_en_o (vref_en_o)
);

// File: tb/tb_codec_pwr_ctrl.sv
module tb_codec_pwr_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE = 64;
  localparam int WARM = 16;
  localparam logic [6:0] IDX = 7'h26;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sync_i = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [6:0]  reg_addr_i = IDX;
  logic [15:0] reg_wdata_i = '0;
  logic [15:0] reg_rdata_o;
  logic adc_en_o, dac_en_o, mix_en_o, vref_en_o, link_en_o, clk_en_o, lnout_en_o;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  codec_pwr_ctrl dut (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [15:0] d);
    @(negedge clk_i);
    reg_addr_i = IDX; reg_wdata_i = d; reg_wr_i = 1'b1;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic sync_pulse(input int n);
    @(negedge clk_i); sync_i = 1'b1;
    wait_clk(n);
    sync_i = 1'b0;
    @(negedge clk_i);
  endtask

  task automatic cold_reset();
    @(negedge clk_i); rst_ni = 1'b0;
    @(negedge clk_i); rst_ni = 1'b1;
  endtask

  function automatic logic [15:0] en_vec();
    return {9'd0, lnout_en_o, clk_en_o, link_en_o, vref_en_o, mix_en_o, dac_en_o, adc_en_o};
  endfunction

  task automatic t_reset();
    cold_reset();
    chk("R9 rdata after reset", reg_rdata_o, 16'h0000);
    chk("R9 enables after reset", en_vec(), 16'h007F);
    wait_clk(SETTLE - 1);
    chk("R9 ready not yet settled", reg_rdata_o, 16'h0000);
    wait_clk(1);
    chk("R1 settled readback", reg_rdata_o, 16'h000F);
    reg_addr_i = 7'h24; #1;
    chk("R1 other address reads zero", reg_rdata_o, 16'h0000);
    reg_addr_i = IDX; #1;
  endtask

  task automatic t_basic();
    wr(16'h010F);
    chk("R2 R11 adc off, ready bits not written", reg_rdata_o, 16'h010E);
    chk("R2 adc_en low only", en_vec(), 16'h007E);
    wr(16'h0600);
    chk("R8 ready drops at once", reg_rdata_o, 16'h0608);
    chk("R2 dac and mix off", en_vec(), 16'h0079);
    wait_clk(SETTLE - 1);
    chk("R8 adc not ready one early", reg_rdata_o, 16'h0608);
    wait_clk(1);
    chk("R8 adc ready at settle count", reg_rdata_o, 16'h0609);
  endtask

  task automatic t_pr3();
    wr(16'h0000); wait_clk(SETTLE);
    wr(16'h0800);
    chk("R3 lone reference bit ignored", reg_rdata_o, 16'h000F);
    chk("R3 reference still on", {15'd0, vref_en_o}, 16'h0001);
    wr(16'h0F00);
    chk("R3 reference bit with lower bits", reg_rdata_o, 16'h0F00);
    chk("R10 all analog enables low", en_vec(), 16'h0070);
    wr(16'h6000);
    chk("R10 clock and line out bits", reg_rdata_o & 16'hFF00, 16'h6000);
    chk("R10 clk and lnout enables", en_vec(), 16'h001F);
    wr(16'h0000); wait_clk(SETTLE);
  endtask

  task automatic t_link();
    wr(16'h1000);
    chk("R4 link bit without adc/dac ignored", {15'd0, link_en_o}, 16'h0001);
    wr(16'h0300);
    wr(16'h1300);
    chk("R4 link shut after adc and dac", {15'd0, link_en_o}, 16'h0000);
    chk("R4 readback", reg_rdata_o & 16'hFF00, 16'h1300);
    wr(16'h0000);
    chk("R5 write ignored while link down", reg_rdata_o & 16'hFF00, 16'h1300);
    sync_pulse(WARM - 1);
    chk("R6 short sync pulse ignored", {15'd0, link_en_o}, 16'h0000);
    sync_pulse(WARM);
    chk("R6 warm reset reopens link", {15'd0, link_en_o}, 16'h0001);
    chk("R6 other bits kept", reg_rdata_o & 16'hFF00, 16'h0300);
    sync_pulse(WARM + 4);
    chk("R7 sync with link up no effect", reg_rdata_o & 16'hFF00, 16'h0300);
    wr(16'h1000);
    chk("R4 link bit needs adc/dac in same write", reg_rdata_o & 16'hFF00, 16'h0000);
  endtask

  task automatic t_cold();
    wr(16'h0300); wr(16'h7F00);
    chk("R9 all bits set before reset", reg_rdata_o & 16'hFF00, 16'h7F00);
    cold_reset();
    chk("R9 cold reset clears all", reg_rdata_o, 16'h0000);
    chk("R9 cold reset enables", en_vec(), 16'h007F);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_pr3();
    t_link();
    t_cold();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule